// File: doc/BRIEF.md
# Motor Fault and Brake Supervisor

This block sits between the protection monitors of a three-phase gate driver and its commutation logic. It takes the Hall sensor code, digital flags from the analog supervisors (supply undervoltage, over-temperature, high-side drain-source excess voltage, bootstrap recharge still busy) and the operator controls: a reset/disable request, a brake request, a brake-select level and a commutation-event pulse. It reduces them to one registered drive mode, a high-side permission, an all-low-sides-on command and an active-high fault flag.

Each fault has its own action and its own clearing rule. An invalid Hall code or over-temperature coasts the bridge. A drain-source short seen while the high sides were allowed is latched and removes only the high sides. It clears at the next commutation event or while reset is asserted. Undervoltage and a rising edge of the reset request are trigger events: the brake-select level is sampled at the onset of each one and held. It then decides between braking and coasting for as long as the event persists. The raw undervoltage flag is debounced by a stability counter of programmable length.

Top module: `mfs_supervisor`

## Requirements
- R1: A Hall code of 3'b000 or 3'b111 gives drive_mode COAST (2'b01) and fault high at the next clock edge. The six other codes cause no fault on their own.
- R2: ot_flag high gives drive_mode COAST and fault high at the next clock edge.
- R3: The filtered undervoltage state follows uv_raw only after uv_raw has differed from it at UV_FILT_CYC consecutive clock edges. The outputs react one edge after that. A shorter excursion in either direction leaves the outputs unchanged.
- R4: While the filtered undervoltage is active, fault is high. drive_mode is BRAKE (2'b10) if brake_sel was 1 at the onset, or COAST if it was 0. Later changes of brake_sel have no effect while the event lasts.
- R5: While reset_cmd is high, hs_enable is low and brake_req is ignored. drive_mode is BRAKE or COAST according to the brake_sel value captured at reset_cmd's rising edge. reset_cmd by itself does not raise fault.
- R6: With no fault and reset_cmd low, brake_req high gives drive_mode BRAKE, with ls_all_on high and hs_enable low.
- R7: ds_over sampled high at an edge where hs_enable was high latches a short fault. This gives drive_mode HSOFF (2'b11), hs_enable low and fault high, and the fault persists after ds_over falls. ds_over while hs_enable is low is ignored.
- R8: The latched short fault clears at an edge where commut_evt or reset_cmd is high.
- R9: boot_busy high forces hs_enable low at the next edge while drive_mode stays RUN (2'b00).
- R10: Coast causes outrank the short-fault high-side inhibit, which outranks brake. hs_enable is only ever high in RUN.
- R11: Under synchronous reset rst, drive_mode is COAST and hs_enable, ls_all_on and fault are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| hall_code | input | 3 | Hall sensor code |
| uv_raw | input | 1 | Unfiltered gate-supply undervoltage flag |
| ot_flag | input | 1 | Over-temperature flag |
| ds_over | input | 1 | High-side drain-source excess voltage flag |
| boot_busy | input | 1 | Bootstrap recharge current still above threshold |
| reset_cmd | input | 1 | Bridge disable request, high = disabled |
| brake_req | input | 1 | Dynamic brake request |
| brake_sel | input | 1 | Brake (1) or coast (0) choice for trigger events |
| commut_evt | input | 1 | One-cycle pulse at each commutation |
| drive_mode | output | 2 | 00 RUN, 01 COAST, 10 BRAKE, 11 HSOFF |
| hs_enable | output | 1 | High-side switches may be turned on |
| ls_all_on | output | 1 | Force all low-side switches on |
| fault | output | 1 | Active-high fault indication |

## Verification
The hardest state to reach from the ports is a latched short fault that meets other causes. The latch arms only if hs_enable was already high at the sampling edge, so the stimulus first parks the block in RUN with boot_busy low. It then pulses ds_over for one cycle and layers brake_req and ot_flag on top to walk the priority ladder before a commutation pulse releases it. The trigger capture is reached by holding uv_raw past the filter length with brake_sel at one value, then flipping brake_sel mid-event. Sub-threshold glitches of uv_raw are injected in both directions.

// File: rtl/mfs_pkg.sv
package mfs_pkg;

  typedef enum logic [1:0] {
    DRV_RUN   = 2'b00,
    DRV_COAST = 2'b01,
    DRV_BRAKE = 2'b10,
    DRV_HSOFF = 2'b11
  } drive_mode_t;

  // Hall codes with all bits equal cannot occur with 120-degree sensors
  function automatic logic hall_code_ok(input logic [2:0] code);
    return (code != 3'b000) && (code != 3'b111);
  endfunction

endpackage

// File: rtl/mfs_uv_filter.sv
module mfs_uv_filter #(
  parameter int STABLE_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic filt
);

  generate
    if (STABLE_CYC <= 1) begin : g_direct
      always_ff @(posedge clk) begin
        if (rst) filt <= 1'b0;
        else     filt <= raw;
      end
    end else begin : g_counted
      localparam int CNT_W = $clog2(STABLE_CYC + 1);
      localparam logic [CNT_W-1:0] LAST = CNT_W'(STABLE_CYC - 1);
      logic [CNT_W-1:0] run_cnt;

      always_ff @(posedge clk) begin
        if (rst) begin
          filt    <= 1'b0;
          run_cnt <= '0;
        end else if (raw == filt) begin
          run_cnt <= '0;
        end else if (run_cnt == LAST) begin
          filt    <= raw;
          run_cnt <= '0;
        end else begin
          run_cnt <= run_cnt + 1'b1;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/mfs_short_latch.sv
module mfs_short_latch (
  input  logic clk,
  input  logic rst,
  input  logic ds_over,
  input  logic hs_was_on,
  input  logic clr,
  output logic short_nxt,
  output logic short_q
);

  // Clearing wins: a commutation starts a fresh observation window
  always_comb begin
    if (clr)                       short_nxt = 1'b0;
    else if (ds_over && hs_was_on) short_nxt = 1'b1;
    else                           short_nxt = short_q;
  end

  always_ff @(posedge clk) begin
    if (rst) short_q <= 1'b0;
    else     short_q <= short_nxt;
  end

endmodule

// File: rtl/mfs_brake_store.sv
module mfs_brake_store (
  input  logic clk,
  input  logic rst,
  input  logic reset_cmd,
  input  logic uv_filt,
  input  logic brake_sel,
  output logic trig_active,
  output logic sel_eff
);

  logic reset_q;
  logic uv_seen;
  logic sel_q;
  logic trig_edge;

  assign trig_edge   = (reset_cmd && !reset_q) || (uv_filt && !uv_seen);
  assign trig_active = reset_cmd || uv_filt;
  assign sel_eff     = trig_edge ? brake_sel : sel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      reset_q <= 1'b0;
      uv_seen <= 1'b0;
      sel_q   <= 1'b0;
    end else begin
      reset_q <= reset_cmd;
      uv_seen <= uv_filt;
      if (trig_edge) sel_q <= brake_sel;
    end
  end

endmodule

// File: rtl/mfs_supervisor.sv
module mfs_supervisor #(
  parameter int UV_FILT_CYC = 4,
  parameter int HALL_W      = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [HALL_W-1:0] hall_code,
  input  logic              uv_raw,
  input  logic              ot_flag,
  input  logic              ds_over,
  input  logic              boot_busy,
  input  logic              reset_cmd,
  input  logic              brake_req,
  input  logic              brake_sel,
  input  logic              commut_evt,
  output logic [1:0]        drive_mode,
  output logic              hs_enable,
  output logic              ls_all_on,
  output logic              fault
);
  import mfs_pkg::*;

  logic        uv_filt;
  logic        trig_active;
  logic        sel_eff;
  logic        short_nxt;
  logic        short_q;
  logic        hall_bad;
  logic        want_coast;
  logic        want_brake;
  drive_mode_t mode_d;
  logic        hs_d;
  logic        fault_d;

  mfs_uv_filter #(.STABLE_CYC(UV_FILT_CYC)) u_uv (
    .clk  (clk),
    .rst  (rst),
    .raw  (uv_raw),
    .filt (uv_filt)
  );

  mfs_brake_store u_store (
    .clk         (clk),
    .rst         (rst),
    .reset_cmd   (reset_cmd),
    .uv_filt     (uv_filt),
    .brake_sel   (brake_sel),
    .trig_active (trig_active),
    .sel_eff     (sel_eff)
  );

  mfs_short_latch u_short (
    .clk       (clk),
    .rst       (rst),
    .ds_over   (ds_over),
    .hs_was_on (hs_enable),
    .clr       (commut_evt || reset_cmd),
    .short_nxt (short_nxt),
    .short_q   (short_q)
  );

  always_comb begin
    hall_bad   = !hall_code_ok(hall_code[2:0]);
    want_coast = hall_bad || ot_flag || (trig_active && !sel_eff);
    want_brake = (trig_active && sel_eff) || (brake_req && !reset_cmd);
    if (want_coast)      mode_d = DRV_COAST;
    else if (short_nxt)  mode_d = DRV_HSOFF;
    else if (want_brake) mode_d = DRV_BRAKE;
    else                 mode_d = DRV_RUN;
    hs_d    = (mode_d == DRV_RUN) && !boot_busy;
    fault_d = hall_bad || ot_flag || uv_filt || short_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      drive_mode <= DRV_COAST;
      hs_enable  <= 1'b0;
      ls_all_on  <= 1'b0;
      fault      <= 1'b0;
    end else begin
      drive_mode <= mode_d;
      hs_enable  <= hs_d;
      ls_all_on  <= (mode_d == DRV_BRAKE);
      fault      <= fault_d;
    end
  end

endmodule

// File: rtl/mfs_supervisor_chk.sv
module mfs_supervisor_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] hall_code,
  input logic       ot_flag,
  input logic       ds_over,
  input logic       boot_busy,
  input logic       reset_cmd,
  input logic       commut_evt,
  input logic [1:0] drive_mode,
  input logic       hs_enable,
  input logic       ls_all_on,
  input logic       fault
);

  p_hall_coast_r1: assert property (@(posedge clk) disable iff (rst)
    (hall_code == 3'b000 || hall_code == 3'b111) |=> (drive_mode == 2'b01 && fault));

  p_ot_coast_r2: assert property (@(posedge clk) disable iff (rst)
    ot_flag |=> (drive_mode == 2'b01 && fault));

  p_reset_no_hs_r5: assert property (@(posedge clk) disable iff (rst)
    reset_cmd |=> !hs_enable);

  p_brake_ls_r6: assert property (@(posedge clk) disable iff (rst)
    ls_all_on |-> !hs_enable);

  p_short_latch_r7: assert property (@(posedge clk) disable iff (rst)
    (hs_enable && ds_over && !commut_evt && !reset_cmd) |=> (!hs_enable && fault));

  p_boot_block_r9: assert property (@(posedge clk) disable iff (rst)
    boot_busy |=> !hs_enable);

  p_hs_only_run_r10: assert property (@(posedge clk) disable iff (rst)
    hs_enable |-> (drive_mode == 2'b00 && !fault));

endmodule

bind mfs_supervisor mfs_supervisor_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .hall_code  (hall_code),
  .ot_flag    (ot_flag),
  .ds_over    (ds_over),
  .boot_busy  (boot_busy),
  .reset_cmd  (reset_cmd),
  .commut_evt (commut_evt),
  .drive_mode (drive_mode),
  .hs_enable  (hs_enable),
  .ls_all_on  (ls_all_on),
  .fault      (fault)
);

// File: tb/mfs_supervisor_test.sv
module mfs_supervisor_test;
  localparam int CLK_P = 10;
  localparam int UVF   = 4;
  localparam logic [1:0] M_RUN = 2'b00, M_COAST = 2'b01, M_BRAKE = 2'b10, M_HSOFF = 2'b11;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] hall_code = 3'b001;
  logic       uv_raw = 1'b0, ot_flag = 1'b0, ds_over = 1'b0, boot_busy = 1'b0;
  logic       reset_cmd = 1'b0, brake_req = 1'b0, brake_sel = 1'b0, commut_evt = 1'b0;
  logic [1:0] drive_mode;
  logic       hs_enable, ls_all_on, fault;

  int n_chk = 0;
  int n_bad = 0;

  mfs_supervisor #(.UV_FILT_CYC(UVF)) uut (
    .clk(clk), .rst(rst), .hall_code(hall_code), .uv_raw(uv_raw),
    .ot_flag(ot_flag), .ds_over(ds_over), .boot_busy(boot_busy),
    .reset_cmd(reset_cmd), .brake_req(brake_req), .brake_sel(brake_sel),
    .commut_evt(commut_evt), .drive_mode(drive_mode), .hs_enable(hs_enable),
    .ls_all_on(ls_all_on), .fault(fault)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic check(input string req, input string what, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic check_all(input string req, input logic [1:0] m, input logic hs,
                           input logic ls, input logic f);
    check(req, "drive_mode", int'(drive_mode), int'(m));
    check(req, "hs_enable", int'(hs_enable), int'(hs));
    check(req, "ls_all_on", int'(ls_all_on), int'(ls));
    check(req, "fault", int'(fault), int'(f));
  endtask

  initial begin
    #(CLK_P * 100000);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk);
    step(2);
    check_all("R11", M_COAST, 1'b0, 1'b0, 1'b0);
    rst = 1'b0;

    // R1 R2 R6 R9 sweep: hall x ot x brake_req x boot_busy
    for (int c = 0; c < 64; c++) begin
      logic bad;
      logic [1:0] em;
      hall_code = c[2:0];
      ot_flag   = c[3];
      brake_req = c[4];
      boot_busy = c[5];
      step();
      bad = (c[2:0] == 3'b000) || (c[2:0] == 3'b111) || c[3];
      em  = bad ? M_COAST : (c[4] ? M_BRAKE : M_RUN);
      check_all("R1/R2/R6/R9 sweep", em, (em == M_RUN) && !c[5], em == M_BRAKE, bad);
    end
    hall_code = 3'b001; ot_flag = 0; brake_req = 0; boot_busy = 0;
    step();
    check_all("R9 idle", M_RUN, 1'b1, 1'b0, 1'b0);

    // R3 R4 undervoltage with brake_sel captured at 1
    brake_sel = 1'b1;
    uv_raw = 1'b1; step(UVF - 1); uv_raw = 1'b0; step(2);
    check_all("R3 short glitch", M_RUN, 1'b1, 1'b0, 1'b0);
    uv_raw = 1'b1; step(UVF);
    check_all("R3 before filter", M_RUN, 1'b1, 1'b0, 1'b0);
    step();
    check_all("R4 uv brake", M_BRAKE, 1'b0, 1'b1, 1'b1);
    brake_sel = 1'b0; step(2);
    check_all("R4 sel change ignored", M_BRAKE, 1'b0, 1'b1, 1'b1);
    uv_raw = 1'b0; step(UVF - 1); uv_raw = 1'b1; step();
    check_all("R3 release glitch", M_BRAKE, 1'b0, 1'b1, 1'b1);
    uv_raw = 1'b0; step(UVF);
    check_all("R3 release before filter", M_BRAKE, 1'b0, 1'b1, 1'b1);
    step();
    check_all("R3 release", M_RUN, 1'b1, 1'b0, 1'b0);
    uv_raw = 1'b1; step(UVF + 1);
    check_all("R4 uv coast", M_COAST, 1'b0, 1'b0, 1'b1);
    uv_raw = 1'b0; step(UVF + 1);
    check_all("R4 uv end", M_RUN, 1'b1, 1'b0, 1'b0);

    // R5 reset request
    brake_sel = 1'b1; reset_cmd = 1'b1; step();
    check_all("R5 reset brake", M_BRAKE, 1'b0, 1'b1, 1'b0);
    brake_sel = 1'b0; brake_req = 1'b1; step(2);
    check_all("R5 held sel", M_BRAKE, 1'b0, 1'b1, 1'b0);
    reset_cmd = 1'b0; step();
    check_all("R6 brake after reset", M_BRAKE, 1'b0, 1'b1, 1'b0);
    reset_cmd = 1'b1; step();
    check_all("R5 reset coast overrides brake", M_COAST, 1'b0, 1'b0, 1'b0);
    reset_cmd = 1'b0; brake_req = 1'b0; step();
    check_all("R5 release", M_RUN, 1'b1, 1'b0, 1'b0);

    // R7 R8 R10 short fault
    ds_over = 1'b1; step(); ds_over = 1'b0;
    check_all("R7 short latch", M_HSOFF, 1'b0, 1'b0, 1'b1);
    step();
    check_all("R7 short held", M_HSOFF, 1'b0, 1'b0, 1'b1);
    brake_req = 1'b1; step();
    check_all("R10 short over brake", M_HSOFF, 1'b0, 1'b0, 1'b1);
    ot_flag = 1'b1; step();
    check_all("R10 coast over short", M_COAST, 1'b0, 1'b0, 1'b1);
    ot_flag = 1'b0; step();
    check_all("R10 short resumes", M_HSOFF, 1'b0, 1'b0, 1'b1);
    commut_evt = 1'b1; step(); commut_evt = 1'b0;
    check_all("R8 commutation clears", M_BRAKE, 1'b0, 1'b1, 1'b0);
    brake_req = 1'b0; step();
    check_all("R8 run again", M_RUN, 1'b1, 1'b0, 1'b0);
    boot_busy = 1'b1; step();
    check_all("R9 boot busy", M_RUN, 1'b0, 1'b0, 1'b0);
    ds_over = 1'b1; step();
    check_all("R7 ignored while hs off", M_RUN, 1'b0, 1'b0, 1'b0);
    ds_over = 1'b0; boot_busy = 1'b0; step();
    check_all("R7 still clear", M_RUN, 1'b1, 1'b0, 1'b0);
    ds_over = 1'b1; step(); ds_over = 1'b0;
    check_all("R7 relatch", M_HSOFF, 1'b0, 1'b0, 1'b1);
    reset_cmd = 1'b1; step();
    check_all("R8 reset clears", M_COAST, 1'b0, 1'b0, 1'b0);
    reset_cmd = 1'b0; step();
    check_all("R8 after reset", M_RUN, 1'b1, 1'b0, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule